// File: doc/BRIEF.md
# IBI Payload Slicer and Queue

This block collects the payload bytes a target sends after an in-band interrupt and turns them into a word-oriented queue for software. Bytes arrive on a valid/ready stream and are held in a byte staging buffer. A finish strobe closes the interrupt. The staged bytes are then cut into slices of a programmable length, and each slice is written to a 32-bit queue as a status header word followed by its data words.

The arbiter that accepted or rejected the interrupt supplies a status word, a rejected flag and a report-enable flag with the finish strobe. A rejected interrupt whose report is disabled leaves the queue untouched. The block keeps the queue occupancy and the slice count of the latest interrupt on its outputs. It serves pop requests from a register port and raises a level-threshold interrupt. Register-bus decoding lives outside.

Top module: `ibi_payload_slicer`

## Requirements
- R1: After reset, in_ready is 1, and rd_data, q_level, stat_count, thld_irq and q_overflow are all 0.
- R2: The slice length in bytes is 4 times data_thld, with 0 read as 1, and any result of 64 or more is limited to 63.
- R3: The staging buffer holds 128 bytes. With 128 bytes staged, in_ready is 0 and a further byte is not taken.
- R4: A finish with fin_nacked=1 and fin_notify=0 writes nothing to the queue and leaves stat_count unchanged. It also discards the staged bytes.
- R5: A finish with no staged bytes writes one header with length 0 and the last bit set, and stat_count becomes 1.
- R6: A header word carries the slice byte length in bits [7:0], the last-slice flag in bit 31, and fin_status[30:8] in bits [30:8]. Full slices carry the slice length. The final slice carries the remaining count, which may be shorter, and sets the last bit. The slice count is the byte count divided by the slice length, rounded up.
- R7: After its header, a slice of L bytes writes ceil(L/4) data words. Each word packs bytes little-endian (first byte in bits [7:0]), and the last word is zero-padded.
- R8: q_level always equals the number of words in the queue. stat_count is set to the number of slices of the latest reported interrupt once its slices are written.
- R9: When the slices have been written, thld_irq is set if q_level is at least stat_thld+1.
- R10: A one-cycle rd_strobe pops the oldest word to rd_data on the next clock edge and lowers q_level by one. On an empty queue it returns 0.
- R11: A pop that leaves q_level below stat_thld+1 clears thld_irq on the same edge.
- R12: The queue holds 16 words. Words written while it is full are dropped and set the sticky q_overflow flag, which only reset clears.
- R13: While slices are being written, in_ready is 0 and no byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_byte | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted when high with in_valid |
| fin_strobe | input | 1 | Interrupt finished, one cycle |
| fin_status | input | 32 | Status word from the arbiter; bits [30:8] reach headers |
| fin_nacked | input | 1 | Interrupt was rejected |
| fin_notify | input | 1 | Report a rejected interrupt |
| data_thld | input | 5 | Slice length field (units of 4 bytes) |
| stat_thld | input | 4 | Level threshold field (threshold = value + 1) |
| rd_strobe | input | 1 | Pop one queue word |
| rd_data | output | 32 | Popped word, registered |
| q_level | output | 5 | Words in the queue |
| stat_count | output | 8 | Slices of the latest reported interrupt |
| thld_irq | output | 1 | Queue level threshold interrupt |
| q_overflow | output | 1 | Sticky: a word was dropped on a full queue |

## Verification
Errors in the slice length or remainder arithmetic show up at the ports as a wrong length byte or last bit in a header word. They also change the number of words between headers, which moves every later word to a new pop position. So a sweep over all length fields and many byte counts exposes such a fault on the first read after the slice boundary. A wrong occupancy count shows in q_level right after the slices are written, and then again when the overflow flag or threshold interrupt fires at the wrong word. Leftover staging bytes, or bytes taken while the block is busy, only appear in the next interrupt. The bench therefore follows such cases with a zero-byte finish, whose single header must read back with length 0.

// File: rtl/ibi_slc_pkg.sv
package ibi_slc_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HLEN_W    = 8;
  localparam int unsigned SLICE_MAX = 63;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_DONE
  } slc_state_e;

  // Slice length in bytes from the length field (units of four bytes).
  function automatic int unsigned slice_bytes(input int unsigned field);
    int unsigned s;
    s = (field == 0) ? 4 : field * 4;
    if (s >= SLICE_MAX + 1) s = SLICE_MAX;
    return s;
  endfunction

endpackage

// File: rtl/ibi_stage_buf.sv
module ibi_stage_buf #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_byte,
  input  logic          rd_en,
  input  logic          flush,
  output logic [7:0]    head,
  output logic [CW-1:0] count,
  output logic          full
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en) wp <= nxt(wp);
      if (rd_en) rp <= nxt(rp);
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign head = mem[rp];
  assign full = (count == CW'(DEPTH));

  // R3
  stage_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R3
  stage_no_wr_full_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_en);

  // R7
  stage_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (count != '0));

endmodule

// File: rtl/ibi_word_fifo.sv
module ibi_word_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  parameter int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_word,
  input  logic          pop,
  output logic [W-1:0]  rd_word,
  output logic [LW-1:0] level,
  output logic          overflow
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_word <= '0;
    end else if (pop) begin
      rd_word <= empty ? '0 : mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      level <= level + LW'(do_push) - LW'(do_pop);
      if (push && full) overflow <= 1'b1;
    end
  end

  // R12
  fifo_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (level == $past(level)) && overflow);

  // R10
  fifo_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (rd_word == '0));

  // R8
  fifo_level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));

  // R12
  fifo_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(overflow) |-> overflow);

endmodule

// File: rtl/ibi_slice_ctrl.sv
module ibi_slice_ctrl
  import ibi_slc_pkg::*;
#(
  parameter int unsigned DT_W = 5,
  parameter int unsigned CW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin,
  input  logic [WORD_W-1:0] fin_base,
  input  logic              fin_nack,
  input  logic              fin_notify,
  input  logic [DT_W-1:0]   dthld,
  input  logic [CW-1:0]     stage_cnt,
  input  logic [7:0]        stage_head,
  output logic              stage_pop,
  output logic              stage_flush,
  output logic              q_push,
  output logic [WORD_W-1:0] q_word,
  output logic              busy,
  output logic              done,
  output logic [CW-1:0]     slices
);

  localparam int unsigned MW = (CW > HLEN_W) ? CW : HLEN_W;

  slc_state_e        state;
  logic [CW-1:0]     rem;
  logic [HLEN_W-1:0] ssz, slen, bidx;
  logic [WORD_W-1:0] base_q, acc;
  logic [CW-1:0]     nslc;

  logic [MW-1:0]     rem_x, ssz_x, cur_len_x;
  logic              last_sl;
  logic [1:0]        lane;
  logic [WORD_W-1:0] word_n;
  logic              end_w, end_sl, suppress;

  assign rem_x     = MW'(rem);
  assign ssz_x     = MW'(ssz);
  assign cur_len_x = (rem_x < ssz_x) ? rem_x : ssz_x;
  assign last_sl   = (rem_x <= ssz_x);
  assign lane      = bidx[1:0];
  assign word_n    = acc | (WORD_W'(stage_head) << {lane, 3'b000});
  assign end_sl    = (bidx == slen - HLEN_W'(1));
  assign end_w     = (lane == 2'd3) || end_sl;
  assign suppress  = fin_nack && !fin_notify;

  always_comb begin
    stage_pop   = 1'b0;
    stage_flush = 1'b0;
    q_push      = 1'b0;
    q_word      = '0;
    case (state)
      ST_IDLE: stage_flush = fin && suppress;
      ST_HDR: begin
        q_push = 1'b1;
        q_word = {last_sl, base_q[WORD_W-2:HLEN_W], cur_len_x[HLEN_W-1:0]};
      end
      ST_DATA: begin
        stage_pop = 1'b1;
        q_push    = end_w;
        q_word    = word_n;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      rem    <= '0;
      ssz    <= '0;
      slen   <= '0;
      bidx   <= '0;
      base_q <= '0;
      acc    <= '0;
      nslc   <= '0;
      slices <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fin && !suppress) begin
            rem    <= stage_cnt;
            ssz    <= HLEN_W'(slice_bytes(32'(dthld)));
            base_q <= fin_base;
            nslc   <= '0;
            state  <= ST_HDR;
          end
        end
        ST_HDR: begin
          nslc  <= nslc + CW'(1);
          rem   <= CW'(rem_x - cur_len_x);
          slen  <= cur_len_x[HLEN_W-1:0];
          bidx  <= '0;
          acc   <= '0;
          state <= (cur_len_x == '0) ? ST_DONE : ST_DATA;
        end
        ST_DATA: begin
          acc  <= end_w ? '0 : word_n;
          bidx <= bidx + HLEN_W'(1);
          if (end_sl) state <= (rem == '0) ? ST_DONE : ST_HDR;
        end
        ST_DONE: begin
          slices <= nslc;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  slice_len_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR) |-> (q_word[HLEN_W-1:0] <= HLEN_W'(SLICE_MAX)));

  // R5
  empty_slice_last_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR && q_word[HLEN_W-1:0] == '0) |-> q_word[WORD_W-1]);

  // R13
  data_has_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> (stage_cnt != '0));

endmodule

// File: rtl/ibi_payload_slicer.sv
module ibi_payload_slicer
  import ibi_slc_pkg::*;
#(
  parameter int unsigned QDEPTH = 16,
  parameter int unsigned SDEPTH = 128,
  parameter int unsigned DT_W   = 5,
  parameter int unsigned ST_W   = 4,
  parameter int unsigned LW     = $clog2(QDEPTH + 1),
  parameter int unsigned CW     = $clog2(SDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              fin_strobe,
  input  logic [WORD_W-1:0] fin_status,
  input  logic              fin_nacked,
  input  logic              fin_notify,
  input  logic [DT_W-1:0]   data_thld,
  input  logic [ST_W-1:0]   stat_thld,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] rd_data,
  output logic [LW-1:0]     q_level,
  output logic [CW-1:0]     stat_count,
  output logic              thld_irq,
  output logic              q_overflow
);

  localparam int unsigned TW = (ST_W + 1 > LW) ? ST_W + 1 : LW;

  logic              st_full, st_pop, st_flush, st_wr, busy, done, q_push;
  logic [7:0]        st_head;
  logic [CW-1:0]     st_cnt;
  logic [WORD_W-1:0] q_word;
  logic [TW-1:0]     thr, lvl;

  assign in_ready = !busy && !st_full && !fin_strobe;
  assign st_wr    = in_valid && in_ready;

  ibi_stage_buf #(.DEPTH(SDEPTH), .CW(CW)) i_stage (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (st_wr),
    .wr_byte (in_byte),
    .rd_en   (st_pop),
    .flush   (st_flush),
    .head    (st_head),
    .count   (st_cnt),
    .full    (st_full)
  );

  ibi_slice_ctrl #(.DT_W(DT_W), .CW(CW)) i_ctrl (
    .clk         (clk),
    .rst         (rst),
    .fin         (fin_strobe),
    .fin_base    (fin_status),
    .fin_nack    (fin_nacked),
    .fin_notify  (fin_notify),
    .dthld       (data_thld),
    .stage_cnt   (st_cnt),
    .stage_head  (st_head),
    .stage_pop   (st_pop),
    .stage_flush (st_flush),
    .q_push      (q_push),
    .q_word      (q_word),
    .busy        (busy),
    .done        (done),
    .slices      (stat_count)
  );

  ibi_word_fifo #(.DEPTH(QDEPTH), .W(WORD_W), .LW(LW)) i_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (q_push),
    .push_word (q_word),
    .pop       (rd_strobe),
    .rd_word   (rd_data),
    .level     (q_level),
    .overflow  (q_overflow)
  );

  assign thr = TW'(stat_thld) + TW'(1);
  assign lvl = TW'(q_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      thld_irq <= 1'b0;
    end else if (rd_strobe && lvl != '0 && (lvl - TW'(1)) < thr) begin
      thld_irq <= 1'b0;
    end else if (done && lvl >= thr) begin
      thld_irq <= 1'b1;
    end
  end

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(thld_irq) |-> $past(done));

  // R11
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(thld_irq) |-> $past(rd_strobe));

  // R13
  no_take_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(st_cnt) || (st_cnt < $past(st_cnt)));

endmodule

// File: tb/test_ibi_payload_slicer.sv
module test_ibi_payload_slicer;

  localparam int CLK_P = 10;
  localparam int QD    = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  in_byte;
  logic        in_valid;
  logic        in_ready;
  logic        fin_strobe;
  logic [31:0] fin_status;
  logic        fin_nacked;
  logic        fin_notify;
  logic [4:0]  data_thld;
  logic [3:0]  stat_thld;
  logic        rd_strobe;
  logic [31:0] rd_data;
  logic [4:0]  q_level;
  logic [7:0]  stat_count;
  logic        thld_irq;
  logic        q_overflow;

  ibi_payload_slicer i_ibi_payload_slicer (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
    .in_ready(in_ready), .fin_strobe(fin_strobe), .fin_status(fin_status),
    .fin_nacked(fin_nacked), .fin_notify(fin_notify), .data_thld(data_thld),
    .stat_thld(stat_thld), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .q_level(q_level), .stat_count(stat_count), .thld_irq(thld_irq),
    .q_overflow(q_overflow)
  );

  always #(CLK_P / 2) clk = ~clk;

  int n_run = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_w [0:511];
  logic [7:0]  stim  [0:255];
  int exp_n, exp_sl;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_byte = '0; fin_strobe = 1'b0;
    fin_nacked = 1'b0; fin_notify = 1'b0; rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic make_stim(input int n, input int seed);
    for (int i = 0; i < n; i++) stim[i] = 8'((seed * 13 + i * 29 + 5) & 255);
  endtask

  // Expected queue content per R2, R5, R6, R7.
  task automatic build(input int f, input int n, input logic [31:0] base);
    int sz, rem, pos, len;
    bit first;
    logic [31:0] word;
    sz = (f == 0) ? 4 : f * 4;
    if (sz >= 64) sz = 63;
    exp_n = 0; exp_sl = 0; rem = n; pos = 0; first = 1'b1;
    while (first || rem > 0) begin
      first = 1'b0;
      len = (rem < sz) ? rem : sz;
      exp_w[exp_n] = {(rem <= sz), base[30:8], 8'(len)};
      exp_n++; exp_sl++;
      for (int w = 0; w < (len + 3) / 4; w++) begin
        word = '0;
        for (int b = 0; b < 4; b++)
          if (w * 4 + b < len) word[8*b +: 8] = stim[pos + w * 4 + b];
        exp_w[exp_n] = word;
        exp_n++;
      end
      pos += len; rem -= len;
    end
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      in_byte = stim[i]; in_valid = 1'b1;
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic finish_ibi(input logic nk, input logic nt, input logic [31:0] base);
    fin_nacked = nk; fin_notify = nt; fin_status = base; fin_strobe = 1'b1;
    @(negedge clk);
    fin_strobe = 1'b0;
    for (int t = 0; t < 2000 && !in_ready; t++) @(negedge clk);
  endtask

  task automatic read_one();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic drain(input int lv, input int thr, input logic irq0, input string rq);
    logic irq_e;
    int l;
    irq_e = irq0; l = lv;
    for (int k = 0; k < lv; k++) begin
      read_one();
      l--;
      if (l < thr) irq_e = 1'b0;
      chk(rq, "pop word", rd_data, exp_w[k]);
      chk("R10", "level after pop", q_level, l);
      chk("R11", "irq after pop", thld_irq, irq_e);
    end
    read_one();
    chk("R10", "empty pop data", rd_data, 0);
    chk("R10", "empty pop level", q_level, 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    int nlist [10];
    int idx, n, mode, thr, lv;
    logic [31:0] base;
    logic nk, nt;
    nlist = '{0, 1, 3, 4, 5, 8, 13, 30, 64, 70};
    data_thld = '0; stat_thld = '0; fin_status = '0;
    do_reset();

    // R1 reset values
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "q_level", q_level, 0);
    chk("R1", "stat_count", stat_count, 0);
    chk("R1", "thld_irq", thld_irq, 0);
    chk("R1", "q_overflow", q_overflow, 0);

    // Sweep: all length fields against many byte counts and report modes.
    idx = 0;
    for (int f = 0; f < 18; f++) begin
      for (int ni = 0; ni < 10; ni++) begin
        n = nlist[ni]; mode = idx % 4; thr = (idx % 16) + 1;
        base = 32'h5A3C_0000 ^ (32'(idx) * 32'h0123_4567);
        nk = (mode == 1 || mode == 2); nt = (mode == 1);
        do_reset();
        data_thld = 5'(f); stat_thld = 4'(thr - 1);
        make_stim(n, idx);
        feed(n);
        finish_ibi(nk, nt, base);
        if (mode == 2) begin
          // R4 suppressed report
          chk("R4", "level after suppressed", q_level, 0);
          chk("R4", "stat_count after suppressed", stat_count, 0);
          chk("R4", "irq after suppressed", thld_irq, 0);
          build(f, 0, base);
          finish_ibi(1'b0, 1'b0, base);
          chk("R4", "staged bytes discarded: level", q_level, 1);
          drain(1, thr, (1 >= thr), "R4");
        end else begin
          build(f, n, base);
          lv = (exp_n < QD) ? exp_n : QD;
          chk((n == 0) ? "R5" : "R8", "stat_count", stat_count, exp_sl);
          chk("R8", "q_level", q_level, lv);
          chk("R12", "overflow", q_overflow, (exp_n > QD));
          chk("R9", "thld_irq", thld_irq, (lv >= thr));
          drain(lv, thr, (lv >= thr), (f == 0 || f >= 16) ? "R2" : "R6_R7");
        end
        idx++;
      end
    end

    // R3 staging full: 128 bytes fill it, a 129th is refused.
    do_reset();
    data_thld = 5'd1; stat_thld = 4'd15;
    make_stim(128, 7);
    feed(128);
    chk("R3", "in_ready when full", in_ready, 0);
    in_byte = 8'hEE; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    finish_ibi(1'b0, 1'b0, 32'h0000_1100);
    chk("R3", "slices of 128 bytes", stat_count, 32);
    chk("R12", "level capped", q_level, 16);
    chk("R12", "overflow set", q_overflow, 1);
    chk("R9", "irq at 16 with threshold 16", thld_irq, 1);
    build(1, 128, 32'h0000_1100);
    drain(16, 16, 1'b1, "R3");
    chk("R12", "overflow sticky", q_overflow, 1);

    // R13 bytes offered while slices are written are not taken.
    do_reset();
    data_thld = 5'd1; stat_thld = 4'd0;
    make_stim(4, 3);
    feed(4);
    fin_status = 32'h00AB_CD00; fin_nacked = 1'b0; fin_notify = 1'b0;
    fin_strobe = 1'b1;
    @(negedge clk);
    fin_strobe = 1'b0;
    in_byte = 8'hAA; in_valid = 1'b1;
    chk("R13", "in_ready while busy", in_ready, 0);
    for (int t = 0; t < 100 && !in_ready; t++) @(negedge clk);
    in_valid = 1'b0;
    chk("R13", "slices", stat_count, 1);
    chk("R13", "level", q_level, 2);
    build(1, 4, 32'h00AB_CD00);
    drain(2, 1, 1'b1, "R13");
    build(1, 0, 32'h00AB_CD00);
    finish_ibi(1'b0, 1'b0, 32'h00AB_CD00);
    chk("R13", "no stray byte: level", q_level, 1);
    drain(1, 1, 1'b1, "R13");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule